// File: doc/BRIEF.md
# Programmable Count Input Decoder

This block is the input stage of a position or event counter. It samples two count inputs, A and B, and a gate input with the system clock, cleans them up, and turns their transitions into single-cycle up and down strobes that a counter core adds or subtracts. The decoding style is set by configuration inputs. In the two plain modes, A and B are either separate up and down clocks, or a clock and a direction level. In the three quadrature modes, A and B are a phase pair that is decoded at one, two or four counts per full cycle.

Each input passes through a two-stage synchronizer and a hold filter. A new level is accepted only after it has been stable for `FILT_LEN` system clocks. The block keeps a direction flag for the most recent quadrature step. Software can ask for a single increment or decrement through one-cycle request strobes. A count enable gates every count, and the gate pin can be configured to block the counts that come from A and B.

Top module: `count_input_decoder`

## Requirements
- R1: With `cfg_quad`=00 and `cfg_dir_mode`=0, each accepted rising edge of A gives exactly one `cnt_up` pulse and each accepted rising edge of B gives exactly one `cnt_dn` pulse. Falling edges give none.
- R2: With `cfg_quad`=00 and `cfg_dir_mode`=1, each accepted rising edge of A gives one count. The count is `cnt_up` if the filtered B is 0 and `cnt_dn` if it is 1. Edges of B alone give none.
- R3: Quadrature phase order is written {A,B}. Forward is 00→10→11→01→00 (A leads B). With `cfg_quad`=11 (x4), every legal single-bit step counts once: `cnt_up` going forward and `cnt_dn` going backward. That is 4 counts per full cycle.
- R4: With `cfg_quad`=10 (x2), only legal steps in which A changes are counted. That is 2 counts per full cycle.
- R5: With `cfg_quad`=01 (x1), the step 00→10 gives `cnt_up` and the step 10→00 gives `cnt_dn`. No other step counts, so a full cycle gives 1 count.
- R6: In any quadrature mode, a step in which A and B change together (an illegal jump) gives no count.
- R7: An input change reaches the decoder only after 2 synchronizer stages and `FILT_LEN` consecutive stable clocks. With `FILT_LEN`=4, a clean A edge gives its strobe after the 7th rising clock edge following the change. A pulse held for fewer than `FILT_LEN` clocks is ignored.
- R8: `dir_up` is 1 after the last legal quadrature step went forward and 0 after it went backward. It is 1 one cycle after `cfg_quad` is 00.
- R9: With `cfg_enable`=0, no counts come from A or B. With `cfg_gate_en`=1 and the filtered gate low, no counts come from A or B. With `cfg_gate_en`=0, the gate pin has no effect.
- R10: A one-cycle `sw_inc` or `sw_dec` gives one `cnt_up` or `cnt_dn` on the next cycle when `cfg_enable`=1, even while the gate is low. It gives nothing when `cfg_enable`=0.
- R11: `cnt_up` and `cnt_dn` are never high together. An up source and a down source in the same cycle cancel, and neither strobe is produced.
- R12: While `rst` is high and on the first cycle after it, `cnt_up` and `cnt_dn` are 0 and `dir_up` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Count input A (asynchronous) |
| in_b | input | 1 | Count input B (asynchronous) |
| in_gate | input | 1 | Gate input, active low when enabled as gate |
| cfg_quad | input | 2 | 00 off, 01 x1, 10 x2, 11 x4 |
| cfg_dir_mode | input | 1 | Non-quadrature: 0 up/down clocks, 1 clock plus direction |
| cfg_enable | input | 1 | Count enable |
| cfg_gate_en | input | 1 | 1: gate pin blocks A/B counts while low |
| sw_inc | input | 1 | Single-increment request strobe |
| sw_dec | input | 1 | Single-decrement request strobe |
| cnt_up | output | 1 | One-cycle up-count strobe |
| cnt_dn | output | 1 | One-cycle down-count strobe |
| dir_up | output | 1 | Last quadrature direction, forced 1 when quadrature is off |

## Verification
The assertions check on every cycle that the two strobes are exclusive, that a disabled block stays quiet, that `dir_up` is forced high when quadrature is off, that an illegal jump never counts, and that the filter only takes up a level the synchronizer presented. Only the bench scenarios can show the count totals per cycle in each multiplier, the direction chosen per step, the exact filter latency, the rejection of short glitches, and the effect of the gate pin and the software strobes. Its random quadrature walks are compared against a step model kept in the bench.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    QM_OFF = 2'b00,
    QM_X1  = 2'b01,
    QM_X2  = 2'b10,
    QM_X4  = 2'b11
  } qmode_t;

  localparam int NUM_IN = 3;  // A, B, gate
  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;
  localparam int IDX_G  = 2;
endpackage

// File: rtl/qdec_in_filter.sv
module qdec_in_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          meta_q, sync_q, filt_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  // Accept a new level once it differed from the held one for FILT_LEN edges
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (sync_q == filt_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      filt_q <= sync_q;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R7: the filter only ever takes up the level the synchronizer presented
  a_r7_filter_follows_sync: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> (filt_q == $past(sync_q)));
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cur_a,
  input  logic   cur_b,
  input  qmode_t quad,
  input  logic   dir_mode,
  output logic   hw_up,
  output logic   hw_dn,
  output logic   dir_up
);
  logic       prev_a, prev_b, dir_q;
  logic [1:0] step;
  logic       fwd, rev, a_chg, a_rise, b_rise;

  function automatic logic [1:0] phase_of(input logic a, input logic b);
    case ({a, b})
      2'b00:   phase_of = 2'd0;
      2'b10:   phase_of = 2'd1;
      2'b11:   phase_of = 2'd2;
      default: phase_of = 2'd3;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= cur_a;
      prev_b <= cur_b;
    end
  end

  always_comb begin
    step   = phase_of(cur_a, cur_b) - phase_of(prev_a, prev_b);
    fwd    = (step == 2'd1);
    rev    = (step == 2'd3);
    a_chg  = cur_a ^ prev_a;
    a_rise = cur_a & ~prev_a;
    b_rise = cur_b & ~prev_b;
    hw_up  = 1'b0;
    hw_dn  = 1'b0;
    case (quad)
      QM_OFF: begin
        if (dir_mode) begin
          hw_up = a_rise & ~cur_b;
          hw_dn = a_rise & cur_b;
        end else begin
          hw_up = a_rise;
          hw_dn = b_rise;
        end
      end
      QM_X1: begin
        hw_up = fwd & ({prev_a, prev_b} == 2'b00);
        hw_dn = rev & ({cur_a, cur_b} == 2'b00);
      end
      QM_X2: begin
        hw_up = fwd & a_chg;
        hw_dn = rev & a_chg;
      end
      default: begin
        hw_up = fwd;
        hw_dn = rev;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                dir_q <= 1'b1;
    else if (quad == QM_OFF) dir_q <= 1'b1;
    else if (fwd)            dir_q <= 1'b1;
    else if (rev)            dir_q <= 1'b0;
  end

  assign dir_up = dir_q;

  // R6: both phases changing at once never yields a quadrature count
  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    ((quad != QM_OFF) && (cur_a != prev_a) && (cur_b != prev_b)) |-> !(hw_up || hw_dn));
endmodule

// File: rtl/count_input_decoder.sv
module count_input_decoder
  import qdec_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       in_gate,
  input  logic [1:0] cfg_quad,
  input  logic       cfg_dir_mode,
  input  logic       cfg_enable,
  input  logic       cfg_gate_en,
  input  logic       sw_inc,
  input  logic       sw_dec,
  output logic       cnt_up,
  output logic       cnt_dn,
  output logic       dir_up
);
  logic [NUM_IN-1:0] raw, filt;
  logic              hw_up, hw_dn, hw_ok, up_src, dn_src;
  logic              up_q, dn_q;
  qmode_t            quad;

  assign raw  = {in_gate, in_b, in_a};
  assign quad = qmode_t'(cfg_quad);

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    qdec_in_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw[gi]),
      .filt_o(filt[gi])
    );
  end

  qdec_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .cur_a   (filt[IDX_A]),
    .cur_b   (filt[IDX_B]),
    .quad    (quad),
    .dir_mode(cfg_dir_mode),
    .hw_up   (hw_up),
    .hw_dn   (hw_dn),
    .dir_up  (dir_up)
  );

  always_comb begin
    hw_ok  = cfg_enable & (~cfg_gate_en | filt[IDX_G]);
    up_src = (hw_ok & hw_up) | (cfg_enable & sw_inc);
    dn_src = (hw_ok & hw_dn) | (cfg_enable & sw_dec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_src & ~dn_src;
      dn_q <= dn_src & ~up_src;
    end
  end

  assign cnt_up = up_q;
  assign cnt_dn = dn_q;

  // R11: strobes exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cnt_up && cnt_dn));
  // R9 / R10: a disabled block produces no strobe on the next cycle
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !(cnt_up || cnt_dn));
  // R8: direction flag forced high with quadrature off
  a_r8_dir_forced: assert property (@(posedge clk) disable iff (rst)
    (cfg_quad == 2'b00) |=> dir_up);
endmodule

// File: tb/sim_count_input_decoder.sv
module sim_count_input_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0, in_gate = 1'b1;
  logic [1:0] cfg_quad = 2'b00;
  logic cfg_dir_mode = 1'b0, cfg_enable = 1'b1, cfg_gate_en = 1'b0;
  logic sw_inc = 1'b0, sw_dec = 1'b0;
  logic cnt_up, cnt_dn, dir_up;

  int total = 0, bad = 0;
  int up_seen = 0, dn_seen = 0;
  int u0s, d0s;
  localparam int HOLD = 10;

  always #5 clk = ~clk;

  count_input_decoder #(.FILT_LEN(4)) u0 (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_gate(in_gate),
    .cfg_quad(cfg_quad), .cfg_dir_mode(cfg_dir_mode), .cfg_enable(cfg_enable),
    .cfg_gate_en(cfg_gate_en), .sw_inc(sw_inc), .sw_dec(sw_dec),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .dir_up(dir_up)
  );

  always @(negedge clk) if (!rst) begin
    up_seen += int'(cnt_up);
    dn_seen += int'(cnt_dn);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    in_a = a; in_b = b;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic mark();
    u0s = up_seen; d0s = dn_seen;
  endtask

  task automatic got(input string req, input int eu, input int ed);
    chk({req, " up"}, up_seen - u0s, eu);
    chk({req, " dn"}, dn_seen - d0s, ed);
  endtask

  // bench model of one filtered quadrature step, returns {up, dn}
  function automatic logic [1:0] qmodel(input int qm, input logic [1:0] p, input logic [1:0] c);
    logic [1:0] seq [4];
    int ip, ic, d;
    logic achg;
    seq[0] = 2'b00; seq[1] = 2'b10; seq[2] = 2'b11; seq[3] = 2'b01;
    ip = 0; ic = 0;
    for (int k = 0; k < 4; k++) begin
      if (seq[k] == p) ip = k;
      if (seq[k] == c) ic = k;
    end
    d = (ic - ip + 4) % 4;
    achg = p[1] ^ c[1];
    if (d != 1 && d != 3) return 2'b00;
    case (qm)
      3: return (d == 1) ? 2'b10 : 2'b01;
      2: return achg ? ((d == 1) ? 2'b10 : 2'b01) : 2'b00;
      1: begin
        if (p == 2'b00 && c == 2'b10) return 2'b10;
        if (p == 2'b10 && c == 2'b00) return 2'b01;
        return 2'b00;
      end
      default: return 2'b00;
    endcase
  endfunction

  task automatic full_cycle(input logic fwd_dir);
    if (fwd_dir) begin
      drive(1,0); drive(1,1); drive(0,1); drive(0,0);
    end else begin
      drive(0,1); drive(1,1); drive(1,0); drive(0,0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R12 up in reset", int'(cnt_up), 0);
    chk("R12 dir in reset", int'(dir_up), 1);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R12 up after reset", int'(cnt_up), 0);
    chk("R12 dn after reset", int'(cnt_dn), 0);
    chk("R12 dir after reset", int'(dir_up), 1);
    repeat (HOLD) @(negedge clk);

    // R7 latency: strobe after 7th rising edge
    in_a = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7 no strobe before 7th edge", int'(cnt_up), 0);
    @(posedge clk); @(negedge clk);
    chk("R7 strobe after 7th edge", int'(cnt_up), 1);
    drive(0,0);

    // R7 glitch of 2 clocks ignored
    mark();
    @(negedge clk); in_a = 1'b1;
    repeat (2) @(negedge clk); in_a = 1'b0;
    repeat (HOLD) @(negedge clk);
    got("R7 short glitch", 0, 0);

    // R1 up/down clocks
    mark(); drive(1,0); drive(0,0); drive(0,1); drive(0,0);
    got("R1 clocks", 1, 1);

    // R2 clock + direction
    cfg_dir_mode = 1'b1;
    mark(); drive(1,0); drive(0,0);
    got("R2 b low up", 1, 0);
    mark(); drive(0,1); drive(1,1); drive(0,1); drive(0,0);
    got("R2 b high down", 0, 1);
    cfg_dir_mode = 1'b0;

    // R3 x4, R8 direction
    cfg_quad = 2'b11;
    mark(); full_cycle(1); got("R3 x4 forward", 4, 0);
    chk("R8 dir fwd", int'(dir_up), 1);
    mark(); full_cycle(0); got("R3 x4 reverse", 0, 4);
    chk("R8 dir rev", int'(dir_up), 0);
    cfg_quad = 2'b00;
    repeat (2) @(negedge clk);
    chk("R8 dir forced quad off", int'(dir_up), 1);

    // R4 x2
    cfg_quad = 2'b10;
    mark(); full_cycle(1); got("R4 x2 forward", 2, 0);
    mark(); full_cycle(0); got("R4 x2 reverse", 0, 2);

    // R5 x1
    cfg_quad = 2'b01;
    mark(); full_cycle(1); got("R5 x1 forward", 1, 0);
    mark(); full_cycle(0); got("R5 x1 reverse", 0, 1);

    // R6 illegal jump
    cfg_quad = 2'b11;
    mark(); drive(1,1); drive(0,0); got("R6 illegal jump", 0, 0);

    // R9 enable and gate
    cfg_enable = 1'b0;
    mark(); full_cycle(1); got("R9 disabled", 0, 0);
    cfg_enable = 1'b1; cfg_gate_en = 1'b1; in_gate = 1'b0;
    repeat (HOLD) @(negedge clk);
    mark(); full_cycle(1); got("R9 gate low blocks", 0, 0);
    // R10 sw strobe not blocked by gate
    mark(); @(negedge clk); sw_inc = 1'b1; @(negedge clk); sw_inc = 1'b0;
    repeat (3) @(negedge clk); got("R10 inc while gated", 1, 0);
    cfg_gate_en = 1'b0;
    mark(); full_cycle(1); got("R9 gate ignored", 4, 0);
    in_gate = 1'b1;
    repeat (HOLD) @(negedge clk);

    // R10 software strobes
    mark(); @(negedge clk); sw_dec = 1'b1; @(negedge clk); sw_dec = 1'b0;
    repeat (3) @(negedge clk); got("R10 dec", 0, 1);
    cfg_enable = 1'b0;
    mark(); @(negedge clk); sw_inc = 1'b1; @(negedge clk); sw_inc = 1'b0;
    repeat (3) @(negedge clk); got("R10 inc disabled", 0, 0);
    cfg_enable = 1'b1;

    // R11 simultaneous requests cancel
    mark(); @(negedge clk); sw_inc = 1'b1; sw_dec = 1'b1;
    @(negedge clk); sw_inc = 1'b0; sw_dec = 1'b0;
    repeat (3) @(negedge clk); got("R11 cancel", 0, 0);

    // Random quadrature walks (R3 R4 R5 R6 R8)
    begin
      logic [1:0] seq [4];
      int idx, eu, ed, r, qm;
      logic edir;
      logic [1:0] res, pv;
      seq[0] = 2'b00; seq[1] = 2'b10; seq[2] = 2'b11; seq[3] = 2'b01;
      idx = 0; edir = 1'b1;
      for (int ph = 0; ph < 6; ph++) begin
        qm = 1 + int'($urandom % 3);
        cfg_quad = 2'(qm);
        repeat (2) @(negedge clk);
        mark(); eu = 0; ed = 0;
        for (int s = 0; s < 40; s++) begin
          pv = seq[idx];
          r = int'($urandom % 8);
          if (r == 0)     idx = (idx + 2) % 4;
          else if (r < 4) idx = (idx + 3) % 4;
          else            idx = (idx + 1) % 4;
          res = qmodel(qm, pv, seq[idx]);
          eu += int'(res[1]); ed += int'(res[0]);
          if (r != 0) edir = (r >= 4);
          drive(seq[idx][1], seq[idx][0]);
        end
        got($sformatf("R3/R4/R5 random x-mode %0d", qm), eu, ed);
        chk("R8 random dir", int'(dir_up), int'(edir));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule